// File: doc/BRIEF.md
# Dual-Select Asynchronous SRAM Sequencer

This block lets clocked logic use an external asynchronous static RAM of 128K bytes. The RAM is selected only when two chip-select lines agree: one is active low and the other active high. The user side is a valid/ready request stream. Each request carries a read/write flag, a 17-bit address and, for writes, one data byte. Read results return on a separate strobe with one byte of data. The memory side drives the address, both selects, the output-enable and write-enable strobes, and the outbound half of the data bus with its driver enable. The pad-level tristate buffer sits outside the block. The data seen on the pins comes back in on a separate input.

Every device timing limit is a nanosecond parameter. It is turned into a clock count by rounding up against the clock period, and no phase is shorter than one clock. Reads hold the address and both strobes for the longer of the cycle time and the access time, then release the device for a turnaround gap. Writes use the late-write form: both selects stay asserted across the whole write-enable pulse and are still asserted when that pulse ends. A sleep input parks the device in low-power retention by pulling the active-high select low. When sleep is removed, no access starts until one full read-cycle time has passed.

Back-pressure rules: a request is taken on any rising clock edge where both valid and ready are high. While ready is low, the requester must hold valid and the request fields stable. Read responses cannot be stalled. Ready is low from the accepting edge until the whole memory cycle, including any turnaround, has finished. Ready is also low while sleep is requested or in force.

Top module: `sram_dualsel_ctrl`

## Requirements
- R1: During and right after reset: ready is 1; the active-low select, output-enable and write-enable are 1; the active-high select is 1; the data driver enable is 0; the response strobe is 0; the sleep status is 0.
- R2: A request is accepted on an edge where valid and ready are both 1. Ready then reads 0 for three clock samples for both reads and writes at the defaults (10 ns clock, 20 ns grade). A request offered while ready is 0 is not consumed.
- R3: A read drives select-low=0, select-high=1, output-enable=0 and write-enable=1 on a stable address for 2 clocks. It captures the data bus on the edge 2 clocks after the accepting edge. The response strobe is 1 for exactly the clock after that edge, carrying the byte last written to that address.
- R4: A write holds write-enable low for 2 clocks, with both selects asserted and the address stable throughout. Write-enable rises while both selects are still asserted. Selects are released 1 clock later.
- R5: The data driver enable is 1 only while write-enable is low and the chip is selected. It is never 1 together with output-enable low. Output-enable falls only when the driver enable was 0 on the previous clock.
- R6: After a read, the chip stays deselected for at least 1 clock before any further access.
- R7: A sleep request is acted on only when idle. If it arrives during a write, the write completes first. In sleep the status output is 1, select-low=1, select-high=0, output-enable=1, write-enable=1 and ready is 0. A request offered during sleep causes no memory access.
- R8: After sleep is removed, ready stays 0 for 2 clock samples (one read-cycle time) before the next request can be accepted.
- R9: If a sleep request and a valid request arrive in the same idle cycle, sleep wins. The request is held off and is accepted after wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data strobe, one clock |
| rsp_rdata | output | 8 | Read byte |
| sleep_req | input | 1 | Request retention standby |
| sleep_active | output | 1 | Device parked in retention |
| mem_addr | output | 17 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select, low in retention |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte driven to the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Byte seen on the data bus |

## Verification
A sleep request and a user request can both fall in the same idle cycle, and sleep must take priority. The bench raises both on the same clock. It then judges that no select activity occurs during sleep and that the recovery gap is honoured. Finally it checks that the held write lands after wake-up by reading it back through the scoreboard. A second overlap, sleep raised in the clock right after a write is accepted, is judged by the write pulse still completing before the device parks.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WRP,
    ST_WRT,
    ST_SLEEP,
    ST_WAKE
  } seq_state_t;

  typedef struct packed {
    logic cs1_n;
    logic cs2;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pin_set_t;

  // nanoseconds to clocks, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // strobe levels for each phase
  function automatic pin_set_t pins_for(input seq_state_t s);
    pin_set_t p;
    p = '{cs1_n: 1'b1, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    case (s)
      ST_RD:    begin p.cs1_n = 1'b0; p.oe_n = 1'b0; end
      ST_WRP:   begin p.cs1_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
      ST_WRT:   p.cs1_n = 1'b0;
      ST_SLEEP: p.cs2 = 1'b0;
      default:  ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] elapsed
);
  // counts clocks spent in the current phase, first clock reads 1
  always_ff @(posedge clk) begin
    if (!rst_n)
      elapsed <= '0;
    else if (clr)
      elapsed <= W'(1);
    else if (elapsed != {W{1'b1}})
      elapsed <= elapsed + W'(1);
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en)
        rsp_rdata <= bus_in;
    end
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int W       = 4,
  parameter int RD_LEN  = 2,
  parameter int AA_CYC  = 2,
  parameter int HZ_CYC  = 1,
  parameter int WP_CYC  = 2,
  parameter int WRT_CYC = 1,
  parameter int RC_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              sleep_req,
  input  logic [W-1:0]      elapsed,
  output logic              req_ready,
  output logic              clr,
  output logic              cap_en,
  output pin_set_t          pins,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              sleep_active
);
  seq_state_t st, nxt;

  assign req_ready    = (st == ST_IDLE) && !sleep_req;
  assign sleep_active = (st == ST_SLEEP);
  assign cap_en       = (st == ST_RD) && (elapsed == W'(AA_CYC));

  always_comb begin
    nxt = st;
    clr = 1'b0;
    case (st)
      ST_IDLE: begin
        if (sleep_req) begin
          nxt = ST_SLEEP;
          clr = 1'b1;
        end else if (req_valid) begin
          nxt = req_write ? ST_WRP : ST_RD;
          clr = 1'b1;
        end
      end
      ST_RD:    if (elapsed == W'(RD_LEN))  begin nxt = ST_TURN; clr = 1'b1; end
      ST_TURN:  if (elapsed == W'(HZ_CYC))  begin nxt = ST_IDLE; clr = 1'b1; end
      ST_WRP:   if (elapsed == W'(WP_CYC))  begin nxt = ST_WRT;  clr = 1'b1; end
      ST_WRT:   if (elapsed == W'(WRT_CYC)) begin nxt = ST_IDLE; clr = 1'b1; end
      ST_SLEEP: if (!sleep_req)             begin nxt = ST_WAKE; clr = 1'b1; end
      ST_WAKE:  if (elapsed == W'(RC_CYC))  begin nxt = ST_IDLE; clr = 1'b1; end
      default:  begin nxt = ST_IDLE; clr = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pins    <= pins_for(ST_IDLE);
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st   <= nxt;
      pins <= pins_for(nxt);
      if (st == ST_IDLE && !sleep_req && req_valid) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/sram_dualsel_ctrl.sv
module sram_dualsel_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 20,
  parameter int T_AA_NS       = 20,
  parameter int T_WC_NS       = 20,
  parameter int T_WP_NS       = 15,
  parameter int T_AW_NS       = 15,
  parameter int T_DW_NS       = 10,
  parameter int T_HZ_NS       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              sleep_req,
  output logic              sleep_active,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RC_CYC  = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
  localparam int AA_CYC  = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                           max2(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS),
                                ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)));
  localparam int RD_LEN  = max2(RC_CYC, AA_CYC);
  localparam int WRT_CYC = max2(1, WC_CYC - WP_CYC);
  localparam int MAX_CYC = max2(max2(RD_LEN, WP_CYC), max2(max2(WRT_CYC, HZ_CYC), RC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  logic             clr;
  logic             cap_en;
  logic [CNT_W-1:0] elapsed;
  pin_set_t         pins;

  sram_phase_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .elapsed(elapsed)
  );

  sram_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(CNT_W), .RD_LEN(RD_LEN),
    .AA_CYC(AA_CYC), .HZ_CYC(HZ_CYC), .WP_CYC(WP_CYC),
    .WRT_CYC(WRT_CYC), .RC_CYC(RC_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .sleep_req(sleep_req),
    .elapsed(elapsed), .req_ready(req_ready), .clr(clr), .cap_en(cap_en),
    .pins(pins), .addr_q(mem_addr), .wdata_q(mem_dq_out),
    .sleep_active(sleep_active)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .bus_in(mem_dq_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign mem_cs1_n = pins.cs1_n;
  assign mem_cs2   = pins.cs2;
  assign mem_oe_n  = pins.oe_n;
  assign mem_we_n  = pins.we_n;
  assign mem_dq_oe = pins.dq_oe;
endmodule

// File: rtl/sram_dualsel_ctrl_chk.sv
module sram_dualsel_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sleep_active,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs1_n,
  input logic              mem_cs2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);
  // R5
  dq_only_in_wpulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_cs1_n && mem_cs2 && mem_oe_n));

  // R5
  oe_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R4
  we_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2));

  // R4
  late_write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs1_n && mem_cs2));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

  // R3
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  sleep_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_active |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !req_ready));
endmodule

bind sram_dualsel_ctrl sram_dualsel_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sram_dualsel_ctrl_test.sv
module sram_dualsel_ctrl_test;
  localparam int AA = 2;   // access clocks at the defaults (R3)
  localparam int RC = 2;   // recovery clocks (R8)
  localparam int WP = 2;   // write pulse clocks (R4)

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, sleep_req = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, sleep_active;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;
  logic mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;

  int total = 0, bad = 0, cyc = 0, conflicts = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_dualsel_ctrl uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model: 256 slots, full address tag per slot
  logic [7:0]  dev_data [256];
  logic [16:0] dev_tag  [256];
  logic        dev_vld  [256];
  int rd_cnt = 0, wl_cnt = 0, desel_cnt = 0;
  logic [16:0] prev_addr = '0, wl_addr = '0;
  logic [7:0]  wl_data = '0;
  logic prev_rd = 0, last_was_rd = 0;

  wire sel    = !mem_cs1_n && mem_cs2;
  wire dev_rd = sel && !mem_oe_n && mem_we_n;
  assign mem_dq_in = (dev_rd && rd_cnt >= AA - 1 && dev_vld[mem_addr[7:0]] &&
                      dev_tag[mem_addr[7:0]] == mem_addr) ? dev_data[mem_addr[7:0]] : 8'hEE;

  initial for (int i = 0; i < 256; i++) dev_vld[i] = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      rd_cnt    <= dev_rd ? ((prev_rd && mem_addr == prev_addr) ? rd_cnt + 1 : 1) : 0;
      prev_rd   <= dev_rd;
      prev_addr <= mem_addr;
      if (sel && !mem_we_n && mem_dq_oe) begin
        wl_cnt  <= wl_cnt + 1;
        wl_addr <= mem_addr;
        wl_data <= mem_dq_out;
      end else if (wl_cnt != 0) begin
        // R4: write ends on WE rising with the chip still selected
        chk(sel && wl_cnt >= WP, "R4", "write pulse clocks", wl_cnt, WP);
        if (sel) begin
          dev_data[wl_addr[7:0]] <= wl_data;
          dev_tag[wl_addr[7:0]]  <= wl_addr;
          dev_vld[wl_addr[7:0]]  <= 1'b1;
        end
        wl_cnt <= 0;
      end
      if (!sel) desel_cnt <= desel_cnt + 1;
      else begin
        // R6: gap after a read before the next selection
        if (desel_cnt != 0 || last_was_rd)
          if (last_was_rd && desel_cnt == 0 && !dev_rd)
            chk(0, "R6", "deselect clocks after read", 0, 1);
        desel_cnt <= 0;
      end
      if (sel) last_was_rd <= dev_rd;
    end
  end

  always @(negedge clk)
    if (rst_n && mem_dq_oe && dev_rd) conflicts++;

  // scoreboard
  typedef struct { logic [7:0] d; int c; } exp_t;
  exp_t exp_q[$];
  logic [7:0] ref_mem [int];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R3", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e.d, "R3", "read data", rsp_rdata, e.d);
        chk(cyc == e.c, "R3", "response clock", cyc, e.c);
      end
    end
  end

  task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int busy;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (wr) ref_mem[int'(a)] = d;
    else begin
      exp_t e;
      e.d = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'hEE;
      e.c = cyc + AA;
      exp_q.push_back(e);
    end
    busy = 0;
    while (!req_ready && busy < 50) begin busy++; @(negedge clk); end
    // R2: three busy samples per access at the defaults
    chk(busy == 3, "R2", "ready low samples", busy, 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    if (!finished) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(req_ready == 1, "R1", "ready", req_ready, 1);
    chk({mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n} == 4'hF, "R1", "strobes",
        {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 4'hF);
    chk(!mem_dq_oe && !rsp_valid && !sleep_active, "R1", "driver/strobe/sleep",
        {mem_dq_oe, rsp_valid, sleep_active}, 0);

    access(1, 17'h00012, 8'hA5);
    access(1, 17'h1FFFF, 8'h3C);
    access(1, 17'h10034, 8'h00);
    access(0, 17'h00012, 8'h00);
    access(0, 17'h1FFFF, 8'h00);
    access(1, 17'h00012, 8'h5A);   // overwrite
    access(0, 17'h00012, 8'h00);
    access(0, 17'h10034, 8'h00);
    access(0, 17'h1FFFF, 8'h00);   // read after read

    // R2: request offered while busy is not consumed twice
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 17'h00077; req_wdata = 8'h77;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 0;                  // stays valid; ready must be low now
    chk(req_ready == 0, "R2", "ready after accept", req_ready, 0);
    req_valid = 0;
    ref_mem[32'h77] = 8'h77;
    while (!req_ready) @(negedge clk);
    access(0, 17'h00077, 8'h00);

    // R9: sleep and request in the same idle cycle
    @(negedge clk);
    sleep_req = 1; req_valid = 1; req_write = 1; req_addr = 17'h0A0A0; req_wdata = 8'hC3;
    @(negedge clk);
    // R7
    chk(sleep_active == 1, "R7", "sleep status", sleep_active, 1);
    chk({mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n} == 4'b1011, "R7", "retention strobes",
        {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b1011);
    n = 0;
    repeat (4) begin
      @(negedge clk);
      if (req_ready || !mem_cs1_n || mem_cs2) n++;
    end
    chk(n == 0, "R9", "request held off during sleep", n, 0);
    sleep_req = 0;
    n = 0;
    @(negedge clk);
    while (!req_ready && n < 50) begin n++; @(negedge clk); end
    // R8
    chk(n == RC, "R8", "recovery clocks", n, RC);
    @(negedge clk);
    req_valid = 0;
    ref_mem[32'hA0A0] = 8'hC3;
    while (!req_ready) @(negedge clk);
    access(0, 17'h0A0A0, 8'h00);    // R9: held write landed

    // R7: sleep raised during a write waits for it
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 17'h00101; req_wdata = 8'h96;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; sleep_req = 1;
    ref_mem[32'h101] = 8'h96;
    chk(sleep_active == 0 && mem_we_n == 0, "R7", "write continues",
        {sleep_active, mem_we_n}, 0);
    n = 0;
    while (!sleep_active && n < 50) begin n++; @(negedge clk); end
    chk(sleep_active == 1, "R7", "sleep after write", sleep_active, 1);
    sleep_req = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    access(0, 17'h00101, 8'h00);

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "responses outstanding", exp_q.size(), 0);
    chk(conflicts == 0, "R5", "bus drive overlap", conflicts, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule